// File: doc/BRIEF.md
# Bus Address-Range Watchpoint Unit

This block watches the memory accesses that the arbiter grants to its clients, one access per cycle. It compares each access against four independent watchpoints. Every watchpoint holds an inclusive address window, a mask of enabled operation types and a mask of enabled clients. When an access matches all three, the watchpoint sets a sticky status bit. When the watchpoint is armed, it also records the details of the access so that software can find out which access tripped it.

Software programs the unit through a simple word-addressed register port with a combinational read. The sticky status bits are gated by an interrupt mask, and the gated bits are ORed onto a single interrupt line. A write-one-to-clear register drops status bits. A separate re-arm register per watchpoint releases its capture registers for the next event. When several watchpoints have status set at once, software services them from watchpoint 0 upward.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset, every status bit, the interrupt mask, all configuration registers and all capture registers read 0, and `irq_o` is low.
- R2: A watchpoint hits in a cycle only if all of these hold:
  - `acc_valid` is 1.
  - `first <= acc_addr <= last`, with both ends inclusive.
  - Bit `acc_op` of its operation mask is 1.
  - Bit `acc_client` of its client mask is 1.
- R3: A watchpoint whose operation mask or client mask is zero never hits.
- R4: A hit sets the watchpoint's status bit, and the bit is readable in the cycle after the access. When several watchpoints hit in the same cycle, all of their bits are set. In the status registers, bit i belongs to watchpoint i.
- R5: The masked status register reads status AND interrupt mask. `irq_o` is high exactly when that value is nonzero.
- R6: Writing the acknowledge register clears each status bit whose write-data bit is 1. A hit in the same cycle as the acknowledge wins, and that bit stays set.
- R7: The first hit after reset or after a re-arm captures the address and an info word:
  - bits [3:0]: client
  - bits [5:4]: operation
  - bits [8:6]: size

  Later hits leave the captured address and info word unchanged until the next re-arm.
- R8: The captured-clients register has bit c set for every client c that hit the watchpoint since the last re-arm.
- R9: Writing the re-arm register of a watchpoint clears its captured clients and arms it again. A hit in the same cycle as the re-arm is captured as the new first hit.
- R10: Register map (word index on `reg_addr`):
  - Watchpoint i, offsets i*8+0 to i*8+7, in order: first address, last address, operation mask, client mask, captured clients (read-only), captured address (read-only), info word (read-only), re-arm (write-only).
  - 0x20: interrupt mask.
  - 0x21: masked status (read-only).
  - 0x22: acknowledge (write-only).
  - 0x23: raw status (read-only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is granted this cycle |
| acc_addr | input | 32 | Access address |
| acc_op | input | 2 | Operation type index |
| acc_client | input | 4 | Client index (0 to 13) |
| acc_size | input | 3 | Access size code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | OR of the masked status bits |

## Verification
Two pairs of events can fall in the same cycle.

A status acknowledge can meet a fresh hit on the same watchpoint. The bench drives the acknowledge write and the matching access in one cycle, then expects the status bit to remain set.

A capture re-arm can meet a hit. The bench writes the re-arm together with an access and expects the captured address, info word and client set to describe that access alone.

Both the checker module and the bench also cover hits from two watchpoints in one cycle.

// File: rtl/awu_pkg.sv
package awu_pkg;
  // Offsets inside one watchpoint's 8-word slot
  localparam logic [2:0] OFF_FIRST  = 3'd0;
  localparam logic [2:0] OFF_LAST   = 3'd1;
  localparam logic [2:0] OFF_OPMSK  = 3'd2;
  localparam logic [2:0] OFF_CLIMSK = 3'd3;
  localparam logic [2:0] OFF_CAPCLI = 3'd4;
  localparam logic [2:0] OFF_CAPADR = 3'd5;
  localparam logic [2:0] OFF_CAPINF = 3'd6;
  localparam logic [2:0] OFF_REARM  = 3'd7;
  // Global register offsets
  localparam logic [1:0] GLB_MASK   = 2'd0;
  localparam logic [1:0] GLB_MSTAT  = 2'd1;
  localparam logic [1:0] GLB_ACK    = 2'd2;
  localparam logic [1:0] GLB_RSTAT  = 2'd3;
endpackage

// File: rtl/awu_window.sv
module awu_window
  import awu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int OPW  = 2,
  parameter int NCLI = 14,
  parameter int CIDW = 4,
  parameter int SZW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_off,
  input  logic [DW-1:0]     wdata,
  input  logic              acc_valid,
  input  logic [AW-1:0]     acc_addr,
  input  logic [OPW-1:0]    acc_op,
  input  logic [CIDW-1:0]   acc_client,
  input  logic [SZW-1:0]    acc_size,
  output logic              hit,
  output logic              armed,
  output logic              rearm,
  output logic [AW-1:0]     cap_addr,
  output logic [(1<<OPW)-1:0] op_mask,
  output logic [NCLI-1:0]   cli_mask,
  output logic [DW-1:0]     rdata
);
  localparam int NOP = 1 << OPW;
  localparam int INFW = SZW + OPW + CIDW;

  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] lo,
                                     input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [NCLI-1:0] client_bit(input logic [CIDW-1:0] c);
    return {{(NCLI-1){1'b0}}, 1'b1} << c;
  endfunction

  logic [AW-1:0]   first_q, last_q;
  logic [NCLI-1:0] cap_cli_q;
  logic [INFW-1:0] cap_inf_q;
  logic            capture;
  logic [NCLI-1:0] cli_onehot;

  assign cli_onehot = client_bit(acc_client);
  assign hit = acc_valid && in_window(acc_addr, first_q, last_q)
               && op_mask[acc_op] && |(cli_mask & cli_onehot);
  assign rearm   = cfg_we && (cfg_off == OFF_REARM);
  assign capture = hit && (armed || rearm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q   <= '0;
      last_q    <= '0;
      op_mask   <= '0;
      cli_mask  <= '0;
      cap_cli_q <= '0;
      cap_addr  <= '0;
      cap_inf_q <= '0;
      armed     <= 1'b1;
    end else begin
      if (cfg_we) begin
        case (cfg_off)
          OFF_FIRST:  first_q  <= wdata[AW-1:0];
          OFF_LAST:   last_q   <= wdata[AW-1:0];
          OFF_OPMSK:  op_mask  <= wdata[NOP-1:0];
          OFF_CLIMSK: cli_mask <= wdata[NCLI-1:0];
          default: ;
        endcase
      end
      cap_cli_q <= (rearm ? '0 : cap_cli_q) | (hit ? cli_onehot : '0);
      if (capture) begin
        cap_addr  <= acc_addr;
        cap_inf_q <= {acc_size, acc_op, acc_client};
        armed     <= 1'b0;
      end else if (rearm) begin
        armed <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (cfg_off)
      OFF_FIRST:  rdata = DW'(first_q);
      OFF_LAST:   rdata = DW'(last_q);
      OFF_OPMSK:  rdata = DW'(op_mask);
      OFF_CLIMSK: rdata = DW'(cli_mask);
      OFF_CAPCLI: rdata = DW'(cap_cli_q);
      OFF_CAPADR: rdata = DW'(cap_addr);
      OFF_CAPINF: rdata = DW'(cap_inf_q);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/awu_irq.sv
module awu_irq #(
  parameter int NWP = 4,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NWP-1:0] hit,
  input  logic           mask_we,
  input  logic           ack_we,
  input  logic [DW-1:0]  wdata,
  output logic [NWP-1:0] status,
  output logic [NWP-1:0] imask,
  output logic [NWP-1:0] masked,
  output logic           irq
);
  logic [NWP-1:0] clr;
  assign clr = ack_we ? wdata[NWP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      imask  <= '0;
    end else begin
      status <= (status & ~clr) | hit;
      if (mask_we) imask <= wdata[NWP-1:0];
    end
  end

  assign masked = status & imask;
  assign irq    = |masked;
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import awu_pkg::*;
#(
  parameter int NWP  = 4,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int OPW  = 2,
  parameter int NCLI = 14,
  parameter int SZW  = 3,
  localparam int CIDW = $clog2(NCLI),
  localparam int WPB  = (NWP > 1) ? $clog2(NWP) : 1,
  localparam int RAW  = WPB + 3 + 1,
  localparam int NOP  = 1 << OPW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic [AW-1:0]   acc_addr,
  input  logic [OPW-1:0]  acc_op,
  input  logic [CIDW-1:0] acc_client,
  input  logic [SZW-1:0]  acc_size,
  input  logic            reg_we,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_o
);
  logic            glb_sel;
  logic [WPB-1:0]  wp_idx;
  logic [2:0]      wp_off;
  logic [1:0]      glb_off;

  assign glb_sel = reg_addr[RAW-1];
  assign wp_idx  = reg_addr[RAW-2:3];
  assign wp_off  = reg_addr[2:0];
  assign glb_off = reg_addr[1:0];

  logic [NWP-1:0]      hit_vec, armed_vec, rearm_vec;
  logic [NWP*AW-1:0]   cap_addr_flat;
  logic [NWP*NOP-1:0]  op_mask_flat;
  logic [NWP*NCLI-1:0] cli_mask_flat;
  logic [DW-1:0]       wp_rdata [NWP];

  for (genvar i = 0; i < NWP; i++) begin : g_wp
    logic we_i;
    assign we_i = reg_we && !glb_sel && (wp_idx == WPB'(i));
    awu_window #(
      .AW(AW), .DW(DW), .OPW(OPW), .NCLI(NCLI), .CIDW(CIDW), .SZW(SZW)
    ) win_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (we_i),
      .cfg_off   (wp_off),
      .wdata     (reg_wdata),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_op    (acc_op),
      .acc_client(acc_client),
      .acc_size  (acc_size),
      .hit       (hit_vec[i]),
      .armed     (armed_vec[i]),
      .rearm     (rearm_vec[i]),
      .cap_addr  (cap_addr_flat[i*AW +: AW]),
      .op_mask   (op_mask_flat[i*NOP +: NOP]),
      .cli_mask  (cli_mask_flat[i*NCLI +: NCLI]),
      .rdata     (wp_rdata[i])
    );
  end

  logic           mask_we, ack_we;
  logic [NWP-1:0] status_vec, imask_vec, masked_vec;

  assign mask_we = reg_we && glb_sel && (glb_off == GLB_MASK);
  assign ack_we  = reg_we && glb_sel && (glb_off == GLB_ACK);

  awu_irq #(.NWP(NWP), .DW(DW)) irq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit_vec),
    .mask_we(mask_we),
    .ack_we (ack_we),
    .wdata  (reg_wdata),
    .status (status_vec),
    .imask  (imask_vec),
    .masked (masked_vec),
    .irq    (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (glb_sel) begin
      case (glb_off)
        GLB_MASK:  reg_rdata = DW'(imask_vec);
        GLB_MSTAT: reg_rdata = DW'(masked_vec);
        GLB_RSTAT: reg_rdata = DW'(status_vec);
        default:   reg_rdata = '0;
      endcase
    end else if (int'(wp_idx) < NWP) begin
      reg_rdata = wp_rdata[wp_idx];
    end
  end
endmodule

// File: rtl/awu_chk.sv
module awu_chk #(
  parameter int NWP  = 4,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NOP  = 4,
  parameter int NCLI = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NWP-1:0]      hit,
  input logic [NWP-1:0]      status,
  input logic [NWP-1:0]      imask,
  input logic                irq,
  input logic                ack_we,
  input logic [DW-1:0]       wdata,
  input logic [NWP-1:0]      armed,
  input logic [NWP-1:0]      rearm,
  input logic [NWP*AW-1:0]   cap_addr,
  input logic [NWP*NOP-1:0]  op_mask,
  input logic [NWP*NCLI-1:0] cli_mask
);
  for (genvar i = 0; i < NWP; i++) begin : g_p
    p_hit_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> status[i]);
    p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !(ack_we && wdata[i])) |=> status[i]);
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && wdata[i] && !hit[i]) |=> !status[i]);
    p_zero_mask_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_mask[i*NOP +: NOP] == '0) || (cli_mask[i*NCLI +: NCLI] == '0)) |-> !hit[i]);
    p_capture_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed[i] && !rearm[i]) |=> $stable(cap_addr[i*AW +: AW]));
  end
  p_irq_needs_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & imask) != '0));
  p_irq_follows_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & imask) != '0) |-> irq);
endmodule

bind addr_watch_unit awu_chk #(
  .NWP(NWP), .AW(AW), .DW(DW), .NOP(NOP), .NCLI(NCLI)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .hit     (hit_vec),
  .status  (status_vec),
  .imask   (imask_vec),
  .irq     (irq_o),
  .ack_we  (ack_we),
  .wdata   (reg_wdata),
  .armed   (armed_vec),
  .rearm   (rearm_vec),
  .cap_addr(cap_addr_flat),
  .op_mask (op_mask_flat),
  .cli_mask(cli_mask_flat)
);

// File: tb/addr_watch_unit_tb_top.sv
module addr_watch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_op = '0;
  logic [3:0]  acc_client = '0;
  logic [2:0]  acc_size = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  always #2 clk = ~clk;

  addr_watch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_op(acc_op), .acc_client(acc_client), .acc_size(acc_size),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  typedef struct {
    logic [5:0]  addr;
    logic [31:0] exp;
    bit          is_irq;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic expect_reg(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.is_irq = 0; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    it.addr = '0; it.exp = {31'd0, e}; it.is_irq = 1; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: pops expected items and compares against the ports
  task automatic drain();
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      @(negedge clk);
      reg_addr = it.addr;
      #1;
      act = it.is_irq ? {31'd0, irq_o} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: addr 0x%0h actual 0x%0h expected 0x%0h",
                 it.tag, it.addr, act, it.exp);
      end
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] op,
                        input logic [3:0] c, input logic [2:0] sz);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_op = op; acc_client = c; acc_size = sz;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic access_with_write(input logic [31:0] a, input logic [1:0] op,
                                   input logic [3:0] c, input logic [2:0] sz,
                                   input logic [5:0] ra, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_op = op; acc_client = c; acc_size = sz;
    reg_we = 1'b1; reg_addr = ra; reg_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; reg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_reg(6'h23, 32'h0, "R1 raw status");
    expect_reg(6'h21, 32'h0, "R1 masked status");
    expect_reg(6'h00, 32'h0, "R1 first addr");
    expect_reg(6'h05, 32'h0, "R1 capture addr");
    expect_irq(1'b0, "R1 irq");
    drain();

    // wp0: window 0x1000..0x10FF, op 1 only, clients 3 and 5
    wr(6'h00, 32'h1000); wr(6'h01, 32'h10FF);
    wr(6'h02, 32'h2);    wr(6'h03, 32'h28);
    wr(6'h20, 32'hF);
    access(32'h0FFF, 2'd1, 4'd3, 3'd0);
    access(32'h1100, 2'd1, 4'd3, 3'd0);
    access(32'h1000, 2'd0, 4'd3, 3'd0);
    access(32'h1000, 2'd1, 4'd4, 3'd0);
    expect_reg(6'h23, 32'h0, "R2 no hit outside window/op/client");
    drain();

    // R2/R4/R5/R7 upper edge hit
    access(32'h10FF, 2'd1, 4'd3, 3'd5);
    expect_reg(6'h23, 32'h1, "R4 status set after hit");
    expect_reg(6'h21, 32'h1, "R5 masked status");
    expect_irq(1'b1, "R5 irq high");
    expect_reg(6'h05, 32'h10FF, "R7 capture addr");
    expect_reg(6'h06, 32'h153, "R7 capture info");
    expect_reg(6'h04, 32'h8, "R8 clients first");
    drain();

    // second hit at lower edge: capture held, clients accumulate
    access(32'h1000, 2'd1, 4'd5, 3'd2);
    expect_reg(6'h05, 32'h10FF, "R7 capture addr held");
    expect_reg(6'h06, 32'h153, "R7 capture info held");
    expect_reg(6'h04, 32'h28, "R8 clients accumulate");
    drain();

    // R3: zero op mask (wp1), zero client mask (wp2)
    wr(6'h08, 32'h0); wr(6'h09, 32'hFFFF_FFFF); wr(6'h0B, 32'h3FFF);
    wr(6'h10, 32'h0); wr(6'h11, 32'hFFFF_FFFF); wr(6'h12, 32'hF);
    access(32'h2000, 2'd2, 4'd7, 3'd1);
    access(32'h0, 2'd0, 4'd0, 3'd1);
    expect_reg(6'h23, 32'h1, "R3 zero masks give no hit");
    drain();

    // R5 masking
    wr(6'h20, 32'h0);
    expect_irq(1'b0, "R5 irq masked off");
    expect_reg(6'h21, 32'h0, "R5 masked status zero");
    expect_reg(6'h23, 32'h1, "R5 raw status kept");
    drain();
    wr(6'h20, 32'hF);

    // R6 acknowledge
    wr(6'h22, 32'h1);
    expect_reg(6'h23, 32'h0, "R6 ack clears");
    expect_irq(1'b0, "R6 irq low after ack");
    drain();
    access_with_write(32'h1004, 2'd1, 4'd3, 3'd0, 6'h22, 32'h1);
    expect_reg(6'h23, 32'h1, "R6 hit wins over ack");
    drain();

    // R9 re-arm then new capture
    wr(6'h07, 32'h0);
    expect_reg(6'h04, 32'h0, "R9 rearm clears clients");
    drain();
    access(32'h1080, 2'd1, 4'd5, 3'd1);
    expect_reg(6'h05, 32'h1080, "R9 new capture addr");
    expect_reg(6'h06, 32'h55, "R9 new capture info");
    expect_reg(6'h04, 32'h20, "R9 new clients");
    drain();
    access_with_write(32'h1010, 2'd1, 4'd3, 3'd0, 6'h07, 32'h0);
    expect_reg(6'h05, 32'h1010, "R9 rearm+hit capture addr");
    expect_reg(6'h06, 32'h13, "R9 rearm+hit capture info");
    expect_reg(6'h04, 32'h8, "R9 rearm+hit clients");
    drain();

    // R4 two watchpoints in one cycle
    wr(6'h18, 32'h1000); wr(6'h19, 32'h1FFF); wr(6'h1A, 32'hF); wr(6'h1B, 32'h3FFF);
    wr(6'h22, 32'hF);
    expect_reg(6'h23, 32'h0, "R6 ack all");
    drain();
    access(32'h1004, 2'd1, 4'd3, 3'd0);
    expect_reg(6'h23, 32'h9, "R4 two watchpoints hit together");
    expect_reg(6'h1D, 32'h1004, "R7 wp3 capture addr");
    expect_reg(6'h05, 32'h1010, "R7 wp0 capture held");
    drain();

    // R10 readback
    expect_reg(6'h01, 32'h10FF, "R10 last addr readback");
    expect_reg(6'h02, 32'h2, "R10 op mask readback");
    expect_reg(6'h03, 32'h28, "R10 client mask readback");
    expect_reg(6'h20, 32'hF, "R10 interrupt mask readback");
    drain();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule